// File: doc/BRIEF.md
# Cross-Queue Event Flag Synchronizer

This block keeps a bank of single-bit hardware event flags. Several instruction queues that run in parallel use these flags to order their work against each other. A producing queue posts a set request that names a flag. The flag is raised only once that instruction reports that all of its memory reads and writes have finished. A consuming queue posts a wait request that names a flag. If the flag is raised, the wait is granted and the flag is consumed. If the flag is low, only that queue stalls, and every other queue carries on.

Each queue has its own set request/grant pair, a completion input and a wait request/grant pair. A queue holds its request until it sees the grant. Grants are combinational within the cycle, and the flag bank updates at the next rising edge. Every cycle the block looks again at each pending wait, so a stalled queue is released in the same cycle that the matching set lands. A set aimed at a flag that is already raised is counted as a lost event, and it raises a sticky overflow indication.

Top module: `queue_event_sync`

## Requirements
- R1: A set request takes effect only in a cycle where the same queue's completion input is also high. That cycle it gets setGrant, and the flag reads as 1 from the next cycle. A completion pulse without a set request changes nothing.
- R2: A wait request on a flag that is 0 gets no waitGrant, and the queue stays blocked for as long as the flag remains 0.
- R3: A wait request on a flag that is 1 gets waitGrant in the same cycle and clears the flag. The next wait on that flag is not granted unless a new set arrives.
- R4: A blocked wait in one queue does not hold back set or wait grants in any other queue.
- R5: A wait held pending over several cycles is granted in the very cycle that a set on its flag is granted.
- R6: When several queues wait on the same raised flag in one cycle, only the lowest-numbered queue is granted. The others keep waiting.
- R7: A set and a wait on the same flag in the same cycle are resolved set-first. The wait is granted and the flag ends at 0.
- R8: A set landing on a flag already at 1 leaves the flag at 1. The same happens when two queues set one flag in the same cycle. Either case raises `overflow` from the next cycle, and it stays high until reset.
- R9: A synchronous reset clears every flag and `overflow`.
- R10: There are 16 flags and five queues. Queue q carries its 4-bit flag index in bits [4q+3:4q] of `setIdx` and of `waitIdx`. Index 0 and index 15 name distinct flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| setReq | input | 5 | Per-queue set-flag request |
| setIdx | input | 20 | Per-queue set flag index, 4 bits per queue |
| accessDone | input | 5 | Per-queue completion of the set instruction's memory accesses |
| setGrant | output | 5 | Per-queue set accepted this cycle |
| waitReq | input | 5 | Per-queue wait-flag request |
| waitIdx | input | 20 | Per-queue wait flag index, 4 bits per queue |
| waitGrant | output | 5 | Per-queue wait satisfied this cycle |
| overflow | output | 1 | Sticky: a set hit a flag that was already raised |

## Verification
Some rules are checked on every cycle. A grant always has a request behind it, and a set without completion is never granted. A lower-numbered waiter on the same flag always beats a higher one. A flag consumed in one cycle cannot satisfy a wait in the next cycle unless a new set arrives. Overflow stays high once raised, and reset clears it. Other behaviour needs the bench's scenarios, because the flag contents are visible only through later grants: the deferred set, release of a long-pending wait, set-before-wait ordering in a shared cycle, double sets and the reset state of all sixteen flags.

// File: rtl/evsync_pkg.sv
package evsync_pkg;
  localparam int QUEUE_CNT = 5;
  localparam int FLAG_CNT  = 16;
  localparam int IDX_W     = $clog2(FLAG_CNT);

  // strobes from control to the flag bank for one cycle
  typedef struct packed {
    logic [FLAG_CNT-1:0] setMask;
    logic [FLAG_CNT-1:0] clrMask;
    logic                ovfHit;
  } flagStrobe_t;
endpackage

// File: rtl/evsync_set_decode.sv
module evsync_set_decode
  import evsync_pkg::*;
#(
  parameter int NQ = QUEUE_CNT,
  parameter int NF = FLAG_CNT,
  localparam int IW = $clog2(NF)
) (
  input  logic [NQ-1:0]    setGrant,
  input  logic [NQ*IW-1:0] setIdx,
  output logic [NF-1:0]    setMask,
  output logic [NF-1:0]    setMulti
);
  // per flag: which queues are setting it this cycle
  for (genvar f = 0; f < NF; f++) begin : g_flag
    logic [NQ-1:0] hitVec;
    for (genvar q = 0; q < NQ; q++) begin : g_q
      assign hitVec[q] = setGrant[q] && (setIdx[q*IW +: IW] == IW'(f));
    end
    assign setMask[f]  = |hitVec;
    assign setMulti[f] = $countones(hitVec) > 1;
  end
endmodule

// File: rtl/evsync_wait_arb.sv
module evsync_wait_arb
  import evsync_pkg::*;
#(
  parameter int NQ = QUEUE_CNT,
  parameter int NF = FLAG_CNT,
  localparam int IW = $clog2(NF)
) (
  input  logic [NQ-1:0]    waitReq,
  input  logic [NQ*IW-1:0] waitIdx,
  input  logic [NF-1:0]    flagAvail,
  output logic [NQ-1:0]    waitGrant,
  output logic [NF-1:0]    taken
);
  logic [NF-1:0][NQ-1:0] grantPerFlag;

  for (genvar f = 0; f < NF; f++) begin : g_flag
    logic [NQ-1:0] reqVec;
    logic [NQ-1:0] lowOne;
    for (genvar q = 0; q < NQ; q++) begin : g_q
      assign reqVec[q] = waitReq[q] && (waitIdx[q*IW +: IW] == IW'(f));
    end
    // fixed priority: lowest queue number wins
    assign lowOne = reqVec & (~reqVec + NQ'(1));
    assign grantPerFlag[f] = flagAvail[f] ? lowOne : '0;
    assign taken[f] = |grantPerFlag[f];
  end

  always_comb begin
    waitGrant = '0;
    for (int f = 0; f < NF; f++) begin
      waitGrant = waitGrant | grantPerFlag[f];
    end
  end
endmodule

// File: rtl/evsync_ctrl.sv
module evsync_ctrl
  import evsync_pkg::*;
#(
  parameter int NQ = QUEUE_CNT,
  localparam int NF = FLAG_CNT,
  localparam int IW = $clog2(NF)
) (
  input  logic [NQ-1:0]    setReq,
  input  logic [NQ*IW-1:0] setIdx,
  input  logic [NQ-1:0]    accessDone,
  input  logic [NQ-1:0]    waitReq,
  input  logic [NQ*IW-1:0] waitIdx,
  input  logic [NF-1:0]    flagQ,
  output logic [NQ-1:0]    setGrant,
  output logic [NQ-1:0]    waitGrant,
  output flagStrobe_t      strobe
);
  logic [NF-1:0] setMask;
  logic [NF-1:0] setMulti;
  logic [NF-1:0] flagAvail;
  logic [NF-1:0] taken;

  // a set is accepted only once its memory accesses are complete
  assign setGrant = setReq & accessDone;

  evsync_set_decode #(.NQ(NQ), .NF(NF)) setDec_i (
    .setGrant (setGrant),
    .setIdx   (setIdx),
    .setMask  (setMask),
    .setMulti (setMulti)
  );

  // set-first ordering: same-cycle sets are visible to waiters
  assign flagAvail = flagQ | setMask;

  evsync_wait_arb #(.NQ(NQ), .NF(NF)) waitArb_i (
    .waitReq   (waitReq),
    .waitIdx   (waitIdx),
    .flagAvail (flagAvail),
    .waitGrant (waitGrant),
    .taken     (taken)
  );

  always_comb begin
    strobe.setMask = setMask;
    strobe.clrMask = taken;
    strobe.ovfHit  = |((flagQ & setMask) | setMulti);
  end
endmodule

// File: rtl/evsync_flags.sv
module evsync_flags
  import evsync_pkg::*;
#(
  localparam int NF = FLAG_CNT
) (
  input  logic        clk,
  input  logic        rst,
  input  flagStrobe_t strobe,
  output logic [NF-1:0] flagQ,
  output logic        ovfQ
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= '0;
      ovfQ  <= 1'b0;
    end else begin
      flagQ <= (flagQ | strobe.setMask) & ~strobe.clrMask;
      if (strobe.ovfHit) ovfQ <= 1'b1;
    end
  end
endmodule

// File: rtl/queue_event_sync.sv
module queue_event_sync
  import evsync_pkg::*;
#(
  parameter int NQ = QUEUE_CNT,
  localparam int NF = FLAG_CNT,
  localparam int IW = $clog2(NF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NQ-1:0]    setReq,
  input  logic [NQ*IW-1:0] setIdx,
  input  logic [NQ-1:0]    accessDone,
  output logic [NQ-1:0]    setGrant,
  input  logic [NQ-1:0]    waitReq,
  input  logic [NQ*IW-1:0] waitIdx,
  output logic [NQ-1:0]    waitGrant,
  output logic             overflow
);
  flagStrobe_t   strobe;
  logic [NF-1:0] flagQ;

  evsync_ctrl #(.NQ(NQ)) ctrl_i (
    .setReq     (setReq),
    .setIdx     (setIdx),
    .accessDone (accessDone),
    .waitReq    (waitReq),
    .waitIdx    (waitIdx),
    .flagQ      (flagQ),
    .setGrant   (setGrant),
    .waitGrant  (waitGrant),
    .strobe     (strobe)
  );

  evsync_flags flags_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .flagQ  (flagQ),
    .ovfQ   (overflow)
  );
endmodule

// File: rtl/evsync_chk.sv
module evsync_chk #(
  parameter int NQ = 5,
  parameter int NF = 16,
  parameter int IW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NQ-1:0]    setReq,
  input logic [NQ*IW-1:0] setIdx,
  input logic [NQ-1:0]    accessDone,
  input logic [NQ-1:0]    setGrant,
  input logic [NQ-1:0]    waitReq,
  input logic [NQ*IW-1:0] waitIdx,
  input logic [NQ-1:0]    waitGrant,
  input logic             overflow
);
  logic [NF-1:0] setNow;
  logic [NF-1:0] grantNow;
  logic [NF-1:0] grantPrev;

  always_comb begin
    setNow   = '0;
    grantNow = '0;
    for (int q = 0; q < NQ; q++) begin
      if (setReq[q] && accessDone[q]) setNow[setIdx[q*IW +: IW]] = 1'b1;
      if (waitGrant[q]) grantNow[waitIdx[q*IW +: IW]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) grantPrev <= '0;
    else     grantPrev <= grantNow;
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    // R1: no set grant before the accesses complete
    p_set_waits_done_r1: assert property (@(posedge clk) disable iff (rst)
      (setReq[q] && !accessDone[q]) |-> !setGrant[q]);
    // R3: a grant always answers a request
    p_grant_has_req_r3: assert property (@(posedge clk) disable iff (rst)
      waitGrant[q] |-> waitReq[q]);
    // R3: a flag consumed last cycle cannot be consumed again without a new set
    p_consumed_r3: assert property (@(posedge clk) disable iff (rst)
      (waitReq[q] && grantPrev[waitIdx[q*IW +: IW]] && !setNow[waitIdx[q*IW +: IW]])
        |-> !waitGrant[q]);
    for (genvar j = q + 1; j < NQ; j++) begin : g_j
      // R6: a higher queue never wins while a lower one waits on the same flag
      p_low_queue_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (waitReq[q] && waitIdx[q*IW +: IW] == waitIdx[j*IW +: IW]) |-> !waitGrant[j]);
    end
  end

  // R8: overflow is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R9: reset clears overflow
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> !overflow);
endmodule

bind queue_event_sync evsync_chk #(.NQ(NQ), .NF(NF), .IW(IW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .setReq     (setReq),
  .setIdx     (setIdx),
  .accessDone (accessDone),
  .setGrant   (setGrant),
  .waitReq    (waitReq),
  .waitIdx    (waitIdx),
  .waitGrant  (waitGrant),
  .overflow   (overflow)
);

// File: tb/queue_event_sync_tb_top.sv
module queue_event_sync_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]  setReq = '0, accessDone = '0, waitReq = '0;
  logic [19:0] setIdx = '0, waitIdx = '0;
  logic [4:0]  setGrant, waitGrant;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  queue_event_sync dut_i (
    .clk(clk), .rst(rst), .setReq(setReq), .setIdx(setIdx),
    .accessDone(accessDone), .setGrant(setGrant), .waitReq(waitReq),
    .waitIdx(waitIdx), .waitGrant(waitGrant), .overflow(overflow)
  );

  typedef struct packed {
    logic [4:0]  sReq;
    logic [4:0]  done;
    logic [19:0] sIdx;
    logic [4:0]  wReq;
    logic [19:0] wIdx;
    logic [4:0]  expSG;
    logic [4:0]  expWG;
    logic        expOv;
    logic [3:0]  reqNo;
  } vec_t;

  // index fields: queue q at bits [4q+3:4q] (R10)
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'b00001, 5'b00000, 20'h00002, 5'b00000, 20'h00000, 5'b00000, 5'b00000, 1'b0, 4'd1}, // R1 no done
    '{5'b00001, 5'b00000, 20'h00002, 5'b00010, 20'h00020, 5'b00000, 5'b00000, 1'b0, 4'd2}, // R2 blocked
    '{5'b00001, 5'b00001, 20'h00002, 5'b00010, 20'h00020, 5'b00001, 5'b00010, 1'b0, 4'd7}, // R7 same cycle
    '{5'b00000, 5'b00000, 20'h00000, 5'b00010, 20'h00020, 5'b00000, 5'b00000, 1'b0, 4'd3}, // R3 consumed
    '{5'b00100, 5'b00100, 20'h00500, 5'b00000, 20'h00000, 5'b00100, 5'b00000, 1'b0, 4'd1}, // R1 set 5
    '{5'b00000, 5'b00000, 20'h00000, 5'b01010, 20'h05050, 5'b00000, 5'b00010, 1'b0, 4'd6}, // R6 Q1 beats Q3
    '{5'b10000, 5'b10000, 20'h70000, 5'b01001, 20'h05009, 5'b10000, 5'b00000, 1'b0, 4'd2}, // R2 Q3 still waits
    '{5'b00000, 5'b00000, 20'h00000, 5'b01001, 20'h05007, 5'b00000, 5'b00001, 1'b0, 4'd4}, // R4 Q0 runs, Q3 blocked
    '{5'b00010, 5'b00010, 20'h000F0, 5'b00000, 20'h00000, 5'b00010, 5'b00000, 1'b0, 4'd1}, // R1 set 15
    '{5'b00100, 5'b00100, 20'h00F00, 5'b00000, 20'h00000, 5'b00100, 5'b00000, 1'b0, 4'd8}, // R8 set on 1
    '{5'b00000, 5'b00000, 20'h00000, 5'b10000, 20'hF0000, 5'b00000, 5'b10000, 1'b1, 4'd8}, // R8 flag kept, ovf up
    '{5'b00000, 5'b00000, 20'h00000, 5'b00100, 20'h00F00, 5'b00000, 5'b00000, 1'b1, 4'd3}, // R3 single token
    '{5'b00000, 5'b11111, 20'h00000, 5'b00000, 20'h00000, 5'b00000, 5'b00000, 1'b1, 4'd1}, // R1 done alone
    '{5'b00000, 5'b00000, 20'h00000, 5'b00001, 20'h00000, 5'b00000, 5'b00000, 1'b1, 4'd1}  // R1 flag 0 still 0
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive after falling edge, sample just before the rising edge
  task automatic apply(input logic [4:0] sr, input logic [4:0] dn, input logic [19:0] si,
                       input logic [4:0] wr, input logic [19:0] wi);
    @(negedge clk);
    setReq = sr; accessDone = dn; setIdx = si; waitReq = wr; waitIdx = wi;
    #8;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    setReq = '0; accessDone = '0; waitReq = '0; setIdx = '0; waitIdx = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    doReset();
    // R9 / R10: reset state, every flag from 0 to 15 empty
    apply(5'b0, 5'b0, 20'h0, 5'b0, 20'h0);
    check("R9", "overflow after reset", 32'(overflow), 32'd0);
    for (int f = 0; f < 16; f++) begin
      apply(5'b0, 5'b0, 20'h0, 5'b00001, 20'(f));
      check("R9", $sformatf("wait flag %0d after reset", f), 32'(waitGrant), 32'd0);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].sReq, VECS[v].done, VECS[v].sIdx, VECS[v].wReq, VECS[v].wIdx);
      check($sformatf("R%0d", VECS[v].reqNo), $sformatf("vec %0d setGrant", v),
            32'(setGrant), 32'(VECS[v].expSG));
      check($sformatf("R%0d", VECS[v].reqNo), $sformatf("vec %0d waitGrant", v),
            32'(waitGrant), 32'(VECS[v].expWG));
      check($sformatf("R%0d", VECS[v].reqNo), $sformatf("vec %0d overflow", v),
            32'(overflow), 32'(VECS[v].expOv));
    end

    // R5: long-pending wait released in the set cycle
    for (int c = 0; c < 3; c++) begin
      apply(5'b0, 5'b0, 20'h0, 5'b01000, 20'h0C000);
      check("R5", "pending wait blocked", 32'(waitGrant), 32'd0);
    end
    apply(5'b00100, 5'b00100, 20'h00C00, 5'b01000, 20'h0C000);
    check("R5", "release setGrant", 32'(setGrant), 32'b00100);
    check("R5", "release waitGrant", 32'(waitGrant), 32'b01000);
    apply(5'b0, 5'b0, 20'h0, 5'b01000, 20'h0C000);
    check("R5", "no second release", 32'(waitGrant), 32'd0);

    // R10: flag 0 and flag 15 are distinct, queue 4 field on top bits
    apply(5'b10000, 5'b10000, 20'h00000, 5'b0, 20'h0);
    check("R10", "set flag 0 from queue 4", 32'(setGrant), 32'b10000);
    apply(5'b0, 5'b0, 20'h0, 5'b00001, 20'h0000F);
    check("R10", "flag 15 untouched", 32'(waitGrant), 32'd0);
    apply(5'b0, 5'b0, 20'h0, 5'b00001, 20'h00000);
    check("R10", "flag 0 raised", 32'(waitGrant), 32'b00001);

    // R8: two sets on one empty flag in the same cycle
    doReset();
    apply(5'b00011, 5'b00011, 20'h00066, 5'b0, 20'h0);
    check("R8", "double set grants", 32'(setGrant), 32'b00011);
    check("R8", "overflow not yet", 32'(overflow), 32'd0);
    apply(5'b0, 5'b0, 20'h0, 5'b00100, 20'h00600);
    check("R8", "overflow after double set", 32'(overflow), 32'd1);
    check("R8", "flag 6 held one event", 32'(waitGrant), 32'b00100);

    // R9: reset clears raised flags and overflow
    apply(5'b00001, 5'b00001, 20'h00003, 5'b0, 20'h0);
    doReset();
    apply(5'b0, 5'b0, 20'h0, 5'b00001, 20'h00003);
    check("R9", "flag 3 cleared by reset", 32'(waitGrant), 32'd0);
    check("R9", "overflow cleared by reset", 32'(overflow), 32'd0);

    apply(5'b0, 5'b0, 20'h0, 5'b0, 20'h0);
    finish();
  end
endmodule